// File: doc/BRIEF.md
# Low-Energy and Startup-Ready Supervisor

This block watches a boost converter's duty controller. It decides whether the storage capacitor has sagged too far to carry the load. The duty controller supplies two inputs. The first is a level that is high while the duty cycle sits at its upper bound. The second is a one-cycle pulse that arrives when the off-time of the switching waveform again exceeds its threshold, which means the duty cycle has come down.

The feedback comparator has hysteresis, so the duty cycle swings up and down all the time. Short visits to the bound are normal and must be ignored. The supervisor raises its low-energy flag only when the bound has been held without a break for a full persistence window. A free-running prescaler produces a slow tick, and a timer counts that tick. With the default values the window is 32000 ticks at 32 kHz, which is one second. The flag stays latched until a recovery pulse arrives.

The same expiry also drives a ready output, which gates the PWM drive at power-up. The ready output rises at the first expiry and then stays high until reset. This keeps a spurious early switching pulse from overcharging the output.

Top module: `low_energy_supervisor`

## Requirements
- R1: After reset, and while `rst` is high, `low_energy_o` and `ready_o` are both 0.
- R2: While `at_bound_i` stays high without a break, `low_energy_o` rises after HOLD_TICKS ticks of the prescaled timer. Each tick lasts TICK_DIV = SYS_CLK_HZ/TICK_HZ clock cycles, so the rise comes no earlier than (HOLD_TICKS-1)*TICK_DIV cycles after `at_bound_i` rises and no later than HOLD_TICKS*TICK_DIV+3 cycles after it.
- R3: A low cycle on `at_bound_i` before the window completes restarts the count from zero. Repeated holds that are each shorter than the window never set `low_energy_o` or `ready_o`.
- R4: Once set, `low_energy_o` stays 1 whether `at_bound_i` stays high or drops, until a recovery pulse arrives.
- R5: A high cycle on `recover_i` clears `low_energy_o` on the next clock edge. Clearing takes priority over setting.
- R6: `ready_o` stays 0 until the first completed window and rises in the same cycle as the first rise of `low_energy_o`.
- R7: Once `ready_o` is 1, it stays 1 until reset, regardless of `at_bound_i` or `recover_i`.
- R8: After a recovery, a new unbroken hold of `at_bound_i` sets `low_energy_o` again within the R2 window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| at_bound_i | input | 1 | High while the duty cycle is held at its upper bound |
| recover_i | input | 1 | One-cycle pulse: off-time exceeded its threshold |
| low_energy_o | output | 1 | Latched low-energy flag |
| ready_o | output | 1 | Startup gate for the PWM drive; sticky once set |

## Verification
Both outputs are registers that follow a registered expiry pulse. The flag and ready outputs therefore change two clock edges after the tick that completes the window, and a recovery pulse clears the flag one edge after it is sampled. The prescaler phase relative to the stimulus is not fixed, so the persistence checks count cycles from the rise of `at_bound_i` and accept the rise only inside the R2 window. Checks of single outputs sample on the falling edge once the relevant rising edges have passed.

// File: rtl/lesup_pkg.sv
package lesup_pkg;
  // Cycles per tick, never below 2 so the tick is a true one-cycle pulse.
  function automatic int tick_divisor(input longint sys_hz, input longint tick_hz);
    longint q;
    q = sys_hz / tick_hz;
    return (q < 2) ? 2 : int'(q);
  endfunction
endpackage

// File: rtl/lesup_prescaler.sv
module lesup_prescaler #(
  parameter int DIV = 6250
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt    <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick_o <= (cnt == LAST);
    end
  end

  // R2: tick lasts a single cycle
  tick_single_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
endmodule

// File: rtl/lesup_persist_timer.sv
module lesup_persist_timer #(
  parameter int HOLD_TICKS = 32000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic hold_i,
  output logic expire_o
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] FULL = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (!hold_i) begin
        cnt <= '0;
      end else if (tick_i && cnt != FULL) begin
        cnt <= cnt + 1'b1;
        if (cnt == LAST) expire_o <= 1'b1;
      end
    end
  end

  // R3: expiry only follows a cycle with the hold condition present
  expire_hold_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |-> $past(hold_i));

  // R2: expiry is a single-cycle event per unbroken hold
  expire_once_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o |=> !expire_o);
endmodule

// File: rtl/low_energy_supervisor.sv
module low_energy_supervisor #(
  parameter longint SYS_CLK_HZ = 200_000_000,
  parameter longint TICK_HZ    = 32_000,
  parameter int     HOLD_TICKS = 32000
) (
  input  logic clk,
  input  logic rst,
  input  logic at_bound_i,
  input  logic recover_i,
  output logic low_energy_o,
  output logic ready_o
);
  import lesup_pkg::*;

  localparam int TICK_DIV = tick_divisor(SYS_CLK_HZ, TICK_HZ);

  logic tick;
  logic expire;

  lesup_prescaler #(.DIV(TICK_DIV)) u_prescaler (
    .clk    (clk),
    .rst    (rst),
    .tick_o (tick)
  );

  lesup_persist_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .tick_i   (tick),
    .hold_i   (at_bound_i),
    .expire_o (expire)
  );

  // Low-energy latch: recovery wins over a coincident expiry.
  always_ff @(posedge clk) begin
    if (rst)            low_energy_o <= 1'b0;
    else if (recover_i) low_energy_o <= 1'b0;
    else if (expire)    low_energy_o <= 1'b1;
  end

  // Startup-ready latch: sticky until reset.
  always_ff @(posedge clk) begin
    if (rst)         ready_o <= 1'b0;
    else if (expire) ready_o <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!low_energy_o && !ready_o));

  // R2
  flag_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(low_energy_o) |-> $past(expire));

  // R5
  recover_clear_chk: assert property (@(posedge clk) disable iff (rst)
    recover_i |=> !low_energy_o);

  // R7
  ready_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    ready_o |=> ready_o);

  // R6
  ready_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> $rose(low_energy_o));
endmodule

// File: tb/test_low_energy_supervisor.sv
module test_low_energy_supervisor;
  localparam longint SYS_HZ = 128;
  localparam longint TCK_HZ = 32;
  localparam int     HOLD   = 20;
  localparam int     DIV    = int'(SYS_HZ / TCK_HZ);
  localparam int     MIN_N  = (HOLD - 1) * DIV;
  localparam int     MAX_N  = HOLD * DIV + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic at_bound = 1'b0;
  logic recover = 1'b0;
  logic low_energy;
  logic ready;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  low_energy_supervisor #(
    .SYS_CLK_HZ (SYS_HZ),
    .TICK_HZ    (TCK_HZ),
    .HOLD_TICKS (HOLD)
  ) i_low_energy_supervisor (
    .clk          (clk),
    .rst          (rst),
    .at_bound_i   (at_bound),
    .recover_i    (recover),
    .low_energy_o (low_energy),
    .ready_o      (ready)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Raise the bound and return the cycle count until the flag is seen.
  task automatic hold_until_flag(output int n, output int rdy_at_rise);
    n = 0;
    rdy_at_rise = 0;
    at_bound = 1'b1;
    while (!low_energy && n < MAX_N + 20) begin
      @(negedge clk);
      n++;
    end
    rdy_at_rise = ready;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    at_bound = 1'b0;
    recover = 1'b0;
    cycles(3);
    check("R1 flag in reset", low_energy, 0);
    check("R1 ready in reset", ready, 0);
    rst = 1'b0;
    cycles(1);
    check("R1 flag after reset", low_energy, 0);
    check("R1 ready after reset", ready, 0);
  endtask

  task automatic t_brief_excursions();
    for (int k = 0; k < 4; k++) begin
      at_bound = 1'b1;
      cycles(MIN_N - 1);
      at_bound = 1'b0;
      cycles(2);
      check("R3 flag after short hold", low_energy, 0);
      check("R3 ready after short hold", ready, 0);
    end
  endtask

  task automatic t_first_hold();
    int n;
    int r;
    check("R6 ready before first window", ready, 0);
    hold_until_flag(n, r);
    check("R2 flag rose", low_energy, 1);
    check("R2 not before window", int'(n >= MIN_N), 1);
    check("R2 not after window", int'(n <= MAX_N), 1);
    check("R6 ready rises with flag", r, 1);
  endtask

  task automatic t_latched();
    cycles(3 * DIV);
    check("R4 flag held while bound high", low_energy, 1);
    at_bound = 1'b0;
    cycles(2 * HOLD * DIV);
    check("R4 flag held after bound drops", low_energy, 1);
  endtask

  task automatic t_recover();
    recover = 1'b1;
    cycles(1);
    recover = 1'b0;
    check("R5 flag cleared by recovery", low_energy, 0);
    check("R7 ready after recovery", ready, 1);
    cycles(5);
    check("R5 flag stays clear", low_energy, 0);
  endtask

  task automatic t_second_hold();
    int n;
    int r;
    hold_until_flag(n, r);
    check("R8 flag set again", low_energy, 1);
    check("R8 within window", int'(n >= MIN_N && n <= MAX_N), 1);
    at_bound = 1'b0;
    recover = 1'b1;
    cycles(1);
    recover = 1'b0;
    check("R5 second clear", low_energy, 0);
  endtask

  task automatic t_ready_sticky();
    at_bound = 1'b1;
    cycles(MIN_N - 1);
    at_bound = 1'b0;
    recover = 1'b1;
    cycles(3);
    recover = 1'b0;
    cycles(2 * HOLD * DIV);
    check("R7 ready stays high", ready, 1);
    check("R3 short hold after recovery", low_energy, 0);
  endtask

  task automatic t_reset_again();
    rst = 1'b1;
    cycles(2);
    check("R1 reset clears ready", ready, 0);
    check("R1 reset clears flag", low_energy, 0);
    rst = 1'b0;
    cycles(2);
  endtask

  initial begin
    cycles(1);
    t_reset();
    t_brief_excursions();
    t_first_hold();
    t_latched();
    t_recover();
    t_second_hold();
    t_ready_sticky();
    t_reset_again();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule